// File: doc/BRIEF.md
# Base-Delta Cache Line Compressor

This block squeezes a 32-byte cache line into a shorter payload by noticing that the values stored in a line often lie close together. Several compression units examine the same line at once. Six of them split the line into elements of a fixed width, take the first element as the base, and try to store every element as a short signed difference. An element may also be stored as a short signed value relative to zero, which acts as a second base. Two further units spot an all-zero line and a line made of one repeated 8-byte value. A selection stage keeps the successful candidate with the fewest bytes. When no unit succeeds, the line is passed through unchanged and marked as raw.

The compressor sits in front of a compressed cache array. A line is offered with a valid/ready handshake. Two clock cycles later, the block returns an encoding code, a payload of up to 32 bytes and the payload length in bytes. The consumer can stall the output, and the pipeline then holds its contents.

Top module: `bdc_compressor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A line accepted at a clock edge (`in_valid` and `in_ready` both 1) appears on the outputs with `out_valid` = 1 exactly two edges later when `out_ready` stays 1. With `out_ready` held at 1, a new line can be accepted on every cycle.
- R3: An all-zero line yields code 1, length 1 and an all-zero payload.
- R4: A non-zero line whose four 8-byte words are all equal yields code 2 and length 8. The payload holds that word in bytes 0 to 7, and every higher byte is zero.
- R5: The base-delta units use these (base bytes, delta bytes) pairs and codes: (8,1)=3, (8,2)=4, (8,4)=5, (4,1)=6, (4,2)=7, (2,1)=8. Elements are little-endian, and element i occupies line bytes i*base to i*base+base-1. The base is element 0. An element fits when its difference from the base, taken modulo 2^(8*base) as a signed number, lies in [-2^(8d-1), 2^(8d-1)-1] for delta width d. A unit succeeds only if every element fits. Its length is base + count*d + ceil(count/8), where count = 32/base.
- R6: An element whose base difference does not fit still fits when its own value, read as a signed number of the base width, lies in the same range. Such an element is stored as that immediate, and its select bit is 1. An element that fits both ways uses the base difference, and its select bit is 0.
- R7: A base-delta payload holds the base little-endian at byte 0. The select bits follow, with element i at bit i%8 of select byte i/8. The d-byte little-endian codes come next, in element order. All bytes beyond the length are zero.
- R8: When no candidate succeeds, the block outputs code 0, length 32 and the line itself as the payload.
- R9: Among the successful candidates, the one with the smallest length is chosen. On a tie, zero beats repeated, which beats base-delta. Between base-delta units, the larger delta width wins, then the smaller base width.
- R10: While `out_valid` is 1 and `out_ready` is 0, the code, length and payload stay unchanged. No accepted line is lost, duplicated or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Offered line is valid |
| in_ready | output | 1 | Compressor can take a line this cycle |
| in_line | input | 256 | Uncompressed line, byte 0 in bits 7:0 |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_flag | output | 4 | Encoding code (0 raw, 1 zero, 2 repeated, 3 to 8 base-delta) |
| out_payload | output | 256 | Compressed bytes, byte 0 in bits 7:0 |
| out_len | output | 6 | Payload length in bytes, 1 to 32 |

## Verification
On every cycle, the assertions check the stall behaviour: results must hold steady under back-pressure, and a staged line must reach the output register. They also check the fixed lengths tied to the zero, repeated and raw codes, and that any non-raw result is strictly shorter than the line. Whether a line was actually compressible, which delta fits at the signed range edges, the use of the zero-relative immediates, the select-bit and byte layout, and the tie order between the (8,1) and (4,1) units can only be shown by the bench. The bench does this by comparing every result against its own byte-level model, using directed lines and a mix of patterned random lines under random stalls.

// File: rtl/bdc_pkg.sv
`timescale 1ns/1ps
package bdc_pkg;

  localparam int LINE_BYTES = 32;
  localparam int LINE_BITS  = LINE_BYTES * 8;
  localparam int LEN_W      = $clog2(LINE_BYTES) + 1;
  localparam int FLAG_W     = 4;
  localparam int NUM_BD     = 6;
  localparam int NUM_CAND   = NUM_BD + 2;
  localparam int WORD_BYTES = 8;

  typedef enum logic [FLAG_W-1:0] {
    ENC_RAW  = 4'd0,
    ENC_ZERO = 4'd1,
    ENC_REP  = 4'd2,
    ENC_B8D1 = 4'd3,
    ENC_B8D2 = 4'd4,
    ENC_B8D4 = 4'd5,
    ENC_B4D1 = 4'd6,
    ENC_B4D2 = 4'd7,
    ENC_B2D1 = 4'd8
  } enc_e;

  typedef struct packed {
    logic                 ok;
    logic [LEN_W-1:0]     len;
    logic [FLAG_W-1:0]    flag;
    logic [LINE_BITS-1:0] payload;
  } cand_t;

  // Unit g sits at priority slot g: larger delta first, then smaller base.
  function automatic int bd_base_bytes(input int g);
    case (g)
      0: return 8;
      1: return 4;
      2: return 8;
      3: return 2;
      4: return 4;
      default: return 8;
    endcase
  endfunction

  function automatic int bd_delta_bytes(input int g);
    case (g)
      0: return 4;
      1: return 2;
      2: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic logic [FLAG_W-1:0] bd_code(input int g);
    case (g)
      0: return ENC_B8D4;
      1: return ENC_B4D2;
      2: return ENC_B8D2;
      3: return ENC_B2D1;
      4: return ENC_B4D1;
      default: return ENC_B8D1;
    endcase
  endfunction

  function automatic int mask_bytes(input int base_b);
    return ((LINE_BYTES / base_b) + 7) / 8;
  endfunction

  function automatic int packed_len(input int base_b, input int delta_b);
    return base_b + (LINE_BYTES / base_b) * delta_b + mask_bytes(base_b);
  endfunction

  // True when v (ebits wide, two's complement) is representable in dbits.
  function automatic logic sext_fits(input logic [63:0] v, input int ebits,
                                     input int dbits);
    logic [63:0] full_m;
    logic [63:0] low_m;
    logic [63:0] chk_m;
    logic [63:0] bits;
    full_m = (ebits >= 64) ? {64{1'b1}} : ((64'd1 << ebits) - 64'd1);
    low_m  = (64'd1 << (dbits - 1)) - 64'd1;
    chk_m  = full_m & ~low_m;
    bits   = v & chk_m;
    return (bits == 64'd0) || (bits == chk_m);
  endfunction

endpackage

// File: rtl/bdc_bd_unit.sv
`timescale 1ns/1ps
module bdc_bd_unit
  import bdc_pkg::*;
#(
  parameter int              BASE_B  = 4,
  parameter int              DELTA_B = 1,
  parameter logic [FLAG_W-1:0] CODE  = ENC_B4D1
) (
  input  logic [LINE_BITS-1:0] line,
  output cand_t                cand
);

  localparam int N      = LINE_BYTES / BASE_B;
  localparam int EB     = BASE_B * 8;
  localparam int DB     = DELTA_B * 8;
  localparam int MB     = mask_bytes(BASE_B);
  localparam int LEN    = packed_len(BASE_B, DELTA_B);
  localparam int CODE_O = BASE_B + MB;

  logic [EB-1:0]         base_val;
  logic [N-1:0]          elem_fit;
  logic [N-1:0]          elem_imm;
  logic [N-1:0][DB-1:0]  elem_code;
  logic [MB*8-1:0]       sel_bits;
  logic [LINE_BITS-1:0]  pay;

  assign base_val = line[EB-1:0];

  for (genvar i = 0; i < N; i++) begin : g_elem
    logic [EB-1:0] elem;
    logic [EB-1:0] diff;
    logic          fit_base;
    logic          fit_zero;
    assign elem     = line[i*EB +: EB];
    assign diff     = elem - base_val;
    assign fit_base = sext_fits(64'(diff), EB, DB);
    assign fit_zero = sext_fits(64'(elem), EB, DB);
    assign elem_fit[i]  = fit_base | fit_zero;
    assign elem_imm[i]  = ~fit_base & fit_zero;
    assign elem_code[i] = fit_base ? diff[DB-1:0] : elem[DB-1:0];
  end

  assign sel_bits = (MB*8)'(elem_imm);

  always_comb begin
    pay = '0;
    pay[EB-1:0] = base_val;
    pay[BASE_B*8 +: MB*8] = sel_bits;
    for (int i = 0; i < N; i++) begin
      pay[(CODE_O + i*DELTA_B)*8 +: DB] = elem_code[i];
    end
  end

  assign cand.ok      = &elem_fit;
  assign cand.len     = LEN_W'(LEN);
  assign cand.flag    = CODE;
  assign cand.payload = pay;

endmodule

// File: rtl/bdc_pattern_unit.sv
`timescale 1ns/1ps
module bdc_pattern_unit
  import bdc_pkg::*;
(
  input  logic [LINE_BITS-1:0] line,
  output cand_t                zero_cand,
  output cand_t                rep_cand
);

  localparam int WORDS  = LINE_BYTES / WORD_BYTES;
  localparam int WBITS  = WORD_BYTES * 8;

  logic [WORDS-1:0] word_same;
  logic             all_zero;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign word_same[w] = (line[w*WBITS +: WBITS] == line[WBITS-1:0]);
  end

  assign all_zero = ~|line;

  assign zero_cand.ok      = all_zero;
  assign zero_cand.len     = LEN_W'(1);
  assign zero_cand.flag    = ENC_ZERO;
  assign zero_cand.payload = '0;

  assign rep_cand.ok      = &word_same;
  assign rep_cand.len     = LEN_W'(WORD_BYTES);
  assign rep_cand.flag    = ENC_REP;
  assign rep_cand.payload = LINE_BITS'(line[WBITS-1:0]);

endmodule

// File: rtl/bdc_select.sv
`timescale 1ns/1ps
module bdc_select
  import bdc_pkg::*;
#(
  parameter int NC = NUM_CAND
) (
  input  logic [LINE_BITS-1:0] line,
  input  cand_t                cands [NC],
  output cand_t                pick
);

  // Slots are scanned in priority order; strict less-than keeps earlier on ties.
  always_comb begin
    pick.ok      = 1'b1;
    pick.len     = LEN_W'(LINE_BYTES);
    pick.flag    = ENC_RAW;
    pick.payload = line;
    for (int c = 0; c < NC; c++) begin
      if (cands[c].ok && (cands[c].len < pick.len)) begin
        pick = cands[c];
      end
    end
  end

endmodule

// File: rtl/bdc_compressor.sv
`timescale 1ns/1ps
module bdc_compressor
  import bdc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [255:0]         in_line,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [3:0]           out_flag,
  output logic [255:0]         out_payload,
  output logic [5:0]           out_len
);

  logic                 s1_valid;
  logic [LINE_BITS-1:0] s1_line;
  logic                 adv_out;
  logic                 adv_in;
  logic                 stage_push;
  cand_t                cands [NUM_CAND];
  cand_t                pick;

  assign adv_out    = ~out_valid | out_ready;
  assign adv_in     = ~s1_valid | adv_out;
  assign stage_push = s1_valid & adv_out;
  assign in_ready   = adv_in;

  bdc_pattern_unit u_pat (
    .line      (s1_line),
    .zero_cand (cands[0]),
    .rep_cand  (cands[1])
  );

  for (genvar g = 0; g < NUM_BD; g++) begin : g_bd
    bdc_bd_unit #(
      .BASE_B  (bd_base_bytes(g)),
      .DELTA_B (bd_delta_bytes(g)),
      .CODE    (bd_code(g))
    ) u_unit (
      .line (s1_line),
      .cand (cands[g+2])
    );
  end

  bdc_select #(.NC(NUM_CAND)) u_sel (
    .line  (s1_line),
    .cands (cands),
    .pick  (pick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_line  <= '0;
    end else if (adv_in) begin
      s1_valid <= in_valid;
      if (in_valid) s1_line <= in_line;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_flag    <= '0;
      out_len     <= '0;
      out_payload <= '0;
    end else if (adv_out) begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_flag    <= pick.flag;
        out_len     <= pick.len;
        out_payload <= pick.payload;
      end
    end
  end

endmodule

// File: rtl/bdc_compressor_chk.sv
`timescale 1ns/1ps
module bdc_compressor_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         out_valid,
  input logic         out_ready,
  input logic [3:0]   out_flag,
  input logic [5:0]   out_len,
  input logic [255:0] out_payload,
  input logic         stage_push
);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_flag) &&
      $stable(out_len) && $stable(out_payload));

  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stage_push |=> out_valid);

  assert_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flag == 4'd1 |-> out_len == 6'd1 && out_payload == '0);

  assert_repeat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flag == 4'd2 |-> out_len == 6'd8 && out_payload[255:64] == '0);

  assert_raw_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flag == 4'd0 |-> out_len == 6'd32);

  assert_shorter_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flag != 4'd0 |-> out_len < 6'd32 && out_flag <= 4'd8);

endmodule

bind bdc_compressor bdc_compressor_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_flag    (out_flag),
  .out_len     (out_len),
  .out_payload (out_payload),
  .stage_push  (stage_push)
);

// File: tb/bdc_compressor_tb.sv
`timescale 1ns/1ps
module bdc_compressor_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] in_line = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [3:0]   out_flag;
  logic [255:0] out_payload;
  logic [5:0]   out_len;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit bp_mode  = 1'b0;
  bit done     = 1'b0;
  string cur_tag = "";

  logic [3:0]   qf[$];
  logic [5:0]   ql[$];
  logic [255:0] qp[$];
  int           qc[$];
  bit           qs[$];
  string        qt[$];

  bit           prev_stall = 1'b0;
  logic [3:0]   hold_f;
  logic [5:0]   hold_l;
  logic [255:0] hold_p;

  always #10 clk = ~clk;

  bdc_compressor u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_line(in_line), .out_valid(out_valid), .out_ready(out_ready),
    .out_flag(out_flag), .out_payload(out_payload), .out_len(out_len)
  );

  // ---------------- reference model ----------------
  function automatic longint sx(input longint unsigned v, input int bits);
    longint t;
    if (bits >= 64) return longint'(v);
    t = longint'(v << (64 - bits));
    return t >>> (64 - bits);
  endfunction

  function automatic bit fits(input longint s, input int dbytes);
    longint lim;
    lim = longint'(1) << (8 * dbytes - 1);
    return (s >= -lim) && (s < lim);
  endfunction

  function automatic longint unsigned elem(input logic [255:0] l, input int b, input int i);
    longint unsigned e = 0;
    for (int k = 0; k < b; k++) e |= {56'd0, l[(i*b+k)*8 +: 8]} << (8 * k);
    return e;
  endfunction

  task automatic try_bd(input logic [255:0] l, input int b, input int d,
                        output bit ok, output int len, output logic [255:0] pay);
    int n, mb;
    longint unsigned base;
    n = 32 / b;
    mb = (n + 7) / 8;
    base = elem(l, b, 0);
    pay = '0;
    ok = 1'b1;
    for (int k = 0; k < b; k++) pay[k*8 +: 8] = 8'(base >> (8 * k));
    for (int i = 0; i < n; i++) begin
      longint unsigned e;
      longint dd, ie, v;
      e  = elem(l, b, i);
      dd = sx(e - base, 8 * b);
      ie = sx(e, 8 * b);
      v  = 0;
      if (fits(dd, d)) v = dd;
      else if (fits(ie, d)) begin
        v = ie;
        pay[(b + i / 8) * 8 + (i % 8)] = 1'b1;
      end else ok = 1'b0;
      for (int k = 0; k < d; k++) pay[(b + mb + i*d + k)*8 +: 8] = 8'(v >>> (8 * k));
    end
    len = b + n * d + mb;
  endtask

  task automatic ref_model(input logic [255:0] l, output logic [3:0] f,
                           output logic [5:0] ln, output logic [255:0] p);
    int bs[6] = '{8, 8, 8, 4, 4, 2};
    int ds[6] = '{1, 2, 4, 1, 2, 1};
    int cs[6] = '{3, 4, 5, 6, 7, 8};
    int best_l, best_d, best_b;
    if (l == '0) begin
      f = 4'd1; ln = 6'd1; p = '0;
      return;
    end
    if (l[63:0] == l[127:64] && l[63:0] == l[191:128] && l[63:0] == l[255:192]) begin
      f = 4'd2; ln = 6'd8; p = {192'd0, l[63:0]};
      return;
    end
    f = 4'd0; p = l; best_l = 32; best_d = 0; best_b = 99;
    for (int c = 0; c < 6; c++) begin
      bit ok;
      int len;
      logic [255:0] pay;
      try_bd(l, bs[c], ds[c], ok, len, pay);
      if (ok && (len < best_l || (len == best_l &&
          (ds[c] > best_d || (ds[c] == best_d && bs[c] < best_b))))) begin
        best_l = len; best_d = ds[c]; best_b = bs[c];
        f = 4'(cs[c]); p = pay;
      end
    end
    ln = 6'(best_l);
  endtask

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      if (prev_stall) begin
        n_checks++;
        if (!(out_valid && out_flag == hold_f && out_len == hold_l && out_payload == hold_p)) begin
          n_fail++;
          $display("FAIL R10 stall hold: got v=%0b f=%0d l=%0d exp v=1 f=%0d l=%0d",
                   out_valid, out_flag, out_len, hold_f, hold_l);
        end
      end
      prev_stall = out_valid && !out_ready;
      hold_f = out_flag; hold_l = out_len; hold_p = out_payload;

      if (in_valid && in_ready) begin
        logic [3:0] f; logic [5:0] ln; logic [255:0] p; string t;
        ref_model(in_line, f, ln, p);
        t = cur_tag;
        if (t == "") t = (f == 4'd0) ? "R8" : (f == 4'd1) ? "R3" : (f == 4'd2) ? "R4" : "R9";
        qf.push_back(f); ql.push_back(ln); qp.push_back(p);
        qc.push_back(cyc); qs.push_back(!bp_mode); qt.push_back(t);
      end
      if (out_valid && out_ready) begin
        n_checks++;
        if (qf.size() == 0) begin
          n_fail++;
          $display("FAIL R10 unexpected output: got f=%0d l=%0d exp none", out_flag, out_len);
        end else begin
          logic [3:0] f; logic [5:0] ln; logic [255:0] p; int c; bit s; string t;
          f = qf.pop_front(); ln = ql.pop_front(); p = qp.pop_front();
          c = qc.pop_front(); s = qs.pop_front(); t = qt.pop_front();
          if (out_flag != f || out_len != ln || out_payload != p) begin
            n_fail++;
            $display("FAIL %s result: got f=%0d l=%0d p=%h exp f=%0d l=%0d p=%h",
                     t, out_flag, out_len, out_payload, f, ln, p);
          end
          if (s) begin
            n_checks++;
            if (cyc - c != 2) begin
              n_fail++;
              $display("FAIL R2 latency: got %0d exp 2", cyc - c);
            end
          end
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [255:0] l, input string tag);
    cur_tag  = tag;
    in_line  = l;
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((qf.size() != 0 || out_valid) && guard < 1000) begin
      @(negedge clk); guard++;
    end
  endtask

  function automatic logic [255:0] gen(input int kind);
    logic [255:0] l = '0;
    case (kind)
      0: l = '0;
      1: begin
        logic [63:0] w = {$urandom, $urandom};
        l = {w, w, w, w};
      end
      2: begin
        logic [31:0] b = $urandom;
        for (int i = 0; i < 8; i++) l[i*32 +: 32] = b + 32'($signed($urandom % 250) - 125);
      end
      3: begin
        logic [15:0] b = 16'($urandom);
        for (int i = 0; i < 16; i++) l[i*16 +: 16] = b + 16'($signed($urandom % 260) - 130);
      end
      4: begin
        logic [63:0] b = {$urandom, $urandom};
        for (int i = 0; i < 4; i++) l[i*64 +: 64] = b + 64'($signed($urandom % 70000) - 35000);
      end
      5: begin
        logic [31:0] b = $urandom | 32'h4000_0000;
        for (int i = 0; i < 8; i++)
          l[i*32 +: 32] = ($urandom % 2 == 0) ? b + 32'($urandom % 100)
                                              : 32'($signed($urandom % 256) - 128);
      end
      default: for (int i = 0; i < 8; i++) l[i*32 +: 32] = $urandom;
    endcase
    return l;
  endfunction

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk); #2;
      out_ready = bp_mode ? ($urandom % 3 != 0) : 1'b1;
    end
  end

  initial begin
    #(20 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    logic [255:0] l;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 reset: got v=%0b rdy=%0b exp v=0 rdy=1", out_valid, in_ready);
    end
    @(posedge clk); #2;

    send('0, "R3");
    send({4{64'h0123_4567_89AB_CDEF}}, "R4");
    for (int i = 0; i < 8; i++) l[i*32 +: 32] = 32'hC040_39C0 + 32'(8 * i);
    send(l, "R7");
    l = {64'd8, 64'd7, 64'd6, 64'd5};
    send(l, "R9");
    l = {32'h0, 32'h8000_1004, 32'h7F, 32'h8000_1020,
         32'hFFFF_FFF0, 32'h8000_1010, 32'h3, 32'h8000_1000};
    send(l, "R6");
    for (int i = 0; i < 16; i++) l[i*16 +: 16] = 16'h1234 + 16'(i) - 16'd8;
    send(l, "R5");
    l = {64'h1111_2222_3333_4444 + 64'd30000, 64'h1111_2222_3333_4444 - 64'd2000,
         64'h1111_2222_3333_4444 + 64'd1000, 64'h1111_2222_3333_4444};
    send(l, "R5");
    l = {64'h1111_2222_3333_4444 + 64'd7, 64'h1111_2222_3333_4444 - 64'd5000000,
         64'h1111_2222_3333_4444 + 64'd100000, 64'h1111_2222_3333_4444};
    send(l, "R5");
    for (int i = 0; i < 8; i++) l[i*32 +: 32] = 32'h4000_0000 + 32'(i * 300) - 32'd900;
    send(l, "R5");
    for (int i = 0; i < 8; i++) l[i*32 +: 32] = $urandom;
    send(l, "R8");
    for (int i = 0; i < 8; i++) l[i*32 +: 32] = 32'h5000_0000 + ((i % 2 == 1) ? 32'd127 : -32'd128);
    l[31:0] = 32'h5000_0000;
    send(l, "R5");
    l[63:32] = 32'h5000_0080;
    send(l, "R5");
    drain();

    for (int i = 0; i < 40; i++) send(gen(i % 7), "R2");
    drain();

    bp_mode = 1'b1;
    for (int i = 0; i < 400; i++) send(gen($urandom % 7), "");
    bp_mode = 1'b0;
    drain();

    n_checks++;
    if (qf.size() != 0) begin
      n_fail++;
      $display("FAIL R10 pending lines: got %0d exp 0", qf.size());
    end
    finish_run();
  end

endmodule